// File: doc/BRIEF.md
# Stepped Voltage Reference Sequencer

This block converts a 5-bit voltage-identification code into a reference level in millivolts for a downstream DAC. It never jumps the reference. After enable it ramps the reference up from zero. After that, whenever the requested code changes, it walks to the new level one 25 mV increment per step tick. A small programmable offset, held to at most 50 mV, is added to the stepped level to form the output.

The code input is filtered before use. A new code is accepted only when the same value has been sampled on two step ticks in a row, so bits that change at slightly different times are not taken as a request. The step tick sets the slew rate: at most one increment happens per tick. A "settled" flag tells the rest of the regulator when the reference has reached its target after the start-up ramp.

All ports are plain level signals. The reference is a continuous value, not a stream of items, so there is no valid/ready handshake and no back-pressure. The output can be read in any cycle.

Top module: `vid_ref_stepper`

## Requirements
- R1: The target for code c (0..30) is 1550 − 25·c mV, so code 00000 gives 1550 mV and code 11110 gives 800 mV. Code 11111 is clamped to 800 mV.
- R2: A code is accepted only when it has been sampled equal on two consecutive step ticks. A value that is present for a single tick is discarded. The accepted code changes only in a cycle with a step tick.
- R3: The internal reference changes only in cycles where step_tick is high. Each such change is exactly +25 mV or −25 mV. The tick on which a code is accepted still steps toward the previous target.
- R4: If the target changes while stepping is under way, the next tick steps toward the new target, even if that means reversing direction.
- R5: One cycle after en rises, the reference starts at 0 mV and then ramps up one step per tick until it reaches the target.
- R6: settled is high only when the start-up ramp has completed and the reference equals the current target. It falls once a new code is accepted.
- R7: While enabled, ref_mv equals the stepped reference plus ofs_mv. Values of ofs_mv above 50 are treated as 50.
- R8: While en is low, ref_mv is 0 and settled is 0 from the next cycle on. A later rise of en restarts the ramp from 0.
- R9: After reset, ref_mv is 0, settled is 0, and the accepted code is 00000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable. Low forces the reference to zero |
| vid_code | input | 5 | Requested voltage code |
| step_tick | input | 1 | One-cycle strobe that paces filtering and stepping |
| ofs_mv | input | 6 | Offset in mV, saturated at 50 |
| ref_mv | output | 11 | Reference output in mV |
| settled | output | 1 | Ramp complete and reference at target |

## Verification
The stepping engine is driven with several input patterns. A start-up ramp from zero to a mid-range code checks the ramp path alone. A downward code change that is overtaken by an upward one mid-sequence shows that retargeting happens at once rather than after the old sequence ends. Single-tick glitches on the code are compared against real two-tick changes, which separates the filter from plain sampling. Manual ticks with long gaps between them confirm that there is exactly one increment per tick and no movement between ticks. The end codes 00000, 11110 and 11111, together with offsets below and above the 50 mV limit, cover the clamps. A disable in the middle of operation followed by re-enable covers the restart.

// File: rtl/vref_pkg.sv
package vref_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RAMP  = 2'd1,
    PH_TRACK = 2'd2
  } ref_phase_e;
endpackage

// File: rtl/vid_code_map.sv
module vid_code_map #(
  parameter int CODE_W   = 5,
  parameter int REF_W    = 11,
  parameter int STEP_MV  = 25,
  parameter int TOP_MV   = 1550,
  parameter int FLOOR_MV = 800
) (
  input  logic [CODE_W-1:0] code,
  output logic [REF_W-1:0]  tgt_mv
);
  localparam int NSTEP = (TOP_MV - FLOOR_MV) / STEP_MV;

  logic [REF_W-1:0] drop_mv;

  always_comb begin
    drop_mv = REF_W'(code) * REF_W'(STEP_MV);
    if (int'(code) > NSTEP) tgt_mv = REF_W'(FLOOR_MV);
    else                    tgt_mv = REF_W'(TOP_MV) - drop_mv;
  end
endmodule

// File: rtl/vid_deskew.sv
module vid_deskew #(
  parameter int CODE_W = 5,
  parameter int AGREE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] vid,
  output logic [CODE_W-1:0] acc_code
);
  localparam int HIST = (AGREE > 1) ? AGREE - 1 : 1;

  logic [CODE_W-1:0] hist_q [HIST];
  logic [HIST-1:0]   match;

  genvar g;
  generate
    for (g = 0; g < HIST; g++) begin : g_cmp
      assign match[g] = (hist_q[g] == vid);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HIST; i++) hist_q[i] <= '0;
      acc_code <= '0;
    end else if (tick) begin
      hist_q[0] <= vid;
      for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
      if (&match) acc_code <= vid;
    end
  end
endmodule

// File: rtl/ref_slew.sv
module ref_slew
  import vref_pkg::*;
#(
  parameter int REF_W   = 11,
  parameter int STEP_MV = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic [REF_W-1:0] tgt_mv,
  output logic [REF_W-1:0] ref_q,
  output logic             active,
  output logic             settled
);
  ref_phase_e       ph_q;
  logic             at_tgt;
  logic             go_up;
  logic [REF_W-1:0] nxt_mv;

  always_comb begin
    at_tgt = (ref_q == tgt_mv);
    go_up  = (ref_q < tgt_mv);
    nxt_mv = go_up ? ref_q + REF_W'(STEP_MV) : ref_q - REF_W'(STEP_MV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      ref_q <= '0;
    end else if (!en) begin
      ph_q  <= PH_IDLE;
      ref_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: ph_q <= PH_RAMP;
        PH_RAMP: begin
          if (at_tgt)    ph_q  <= PH_TRACK;
          else if (tick) ref_q <= nxt_mv;
        end
        PH_TRACK: begin
          if (tick && !at_tgt) ref_q <= nxt_mv;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign active  = (ph_q != PH_IDLE);
  assign settled = (ph_q == PH_TRACK) && at_tgt;
endmodule

// File: rtl/ref_offset_sum.sv
module ref_offset_sum #(
  parameter int REF_W      = 11,
  parameter int OFS_W      = 6,
  parameter int OFS_MAX_MV = 50
) (
  input  logic [REF_W-1:0] ref_in,
  input  logic [OFS_W-1:0] ofs_in,
  input  logic             active,
  output logic [REF_W-1:0] sum_mv
);
  logic [OFS_W-1:0] ofs_sat;

  always_comb begin
    ofs_sat = (ofs_in > OFS_W'(OFS_MAX_MV)) ? OFS_W'(OFS_MAX_MV) : ofs_in;
    sum_mv  = active ? ref_in + REF_W'(ofs_sat) : '0;
  end
endmodule

// File: rtl/vid_ref_stepper.sv
module vid_ref_stepper #(
  parameter int CODE_W     = 5,
  parameter int REF_W      = 11,
  parameter int OFS_W      = 6,
  parameter int STEP_MV    = 25,
  parameter int TOP_MV     = 1550,
  parameter int FLOOR_MV   = 800,
  parameter int OFS_MAX_MV = 50,
  parameter int AGREE      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] vid_code,
  input  logic              step_tick,
  input  logic [OFS_W-1:0]  ofs_mv,
  output logic [REF_W-1:0]  ref_mv,
  output logic              settled
);
  logic [CODE_W-1:0] acc_code;
  logic [REF_W-1:0]  tgt_mv;
  logic [REF_W-1:0]  ref_raw;
  logic              active;

  vid_deskew #(.CODE_W(CODE_W), .AGREE(AGREE)) u_deskew (
    .clk(clk), .rst_n(rst_n), .tick(step_tick), .vid(vid_code), .acc_code(acc_code)
  );

  vid_code_map #(
    .CODE_W(CODE_W), .REF_W(REF_W), .STEP_MV(STEP_MV),
    .TOP_MV(TOP_MV), .FLOOR_MV(FLOOR_MV)
  ) u_map (
    .code(acc_code), .tgt_mv(tgt_mv)
  );

  ref_slew #(.REF_W(REF_W), .STEP_MV(STEP_MV)) u_slew (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(step_tick), .tgt_mv(tgt_mv),
    .ref_q(ref_raw), .active(active), .settled(settled)
  );

  ref_offset_sum #(.REF_W(REF_W), .OFS_W(OFS_W), .OFS_MAX_MV(OFS_MAX_MV)) u_sum (
    .ref_in(ref_raw), .ofs_in(ofs_mv), .active(active), .sum_mv(ref_mv)
  );
endmodule

// File: rtl/vid_ref_stepper_chk.sv
module vid_ref_stepper_chk #(
  parameter int CODE_W     = 5,
  parameter int REF_W      = 11,
  parameter int STEP_MV    = 25,
  parameter int TOP_MV     = 1550,
  parameter int FLOOR_MV   = 800,
  parameter int OFS_MAX_MV = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              step_tick,
  input logic [REF_W-1:0]  ref_mv,
  input logic              settled,
  input logic [REF_W-1:0]  ref_raw,
  input logic [REF_W-1:0]  tgt_mv,
  input logic [CODE_W-1:0] acc_code
);
  AST_TGT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tgt_mv) >= FLOOR_MV && int'(tgt_mv) <= TOP_MV); // R1

  AST_ACC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(acc_code)); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step_tick) |=> $stable(ref_raw)); // R3

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step_tick) |=> (ref_raw == $past(ref_raw) ||
                           ref_raw == $past(ref_raw) + REF_W'(STEP_MV) ||
                           ref_raw + REF_W'(STEP_MV) == $past(ref_raw))); // R3

  AST_SETTLED_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> $past(en)); // R6

  AST_OUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (int'(ref_mv) >= int'(tgt_mv) &&
                 int'(ref_mv) <= int'(tgt_mv) + OFS_MAX_MV)); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ref_mv == '0 && !settled)); // R8
endmodule

bind vid_ref_stepper vid_ref_stepper_chk #(
  .CODE_W(CODE_W), .REF_W(REF_W), .STEP_MV(STEP_MV),
  .TOP_MV(TOP_MV), .FLOOR_MV(FLOOR_MV), .OFS_MAX_MV(OFS_MAX_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .step_tick(step_tick),
  .ref_mv(ref_mv), .settled(settled), .ref_raw(ref_raw),
  .tgt_mv(tgt_mv), .acc_code(acc_code)
);

// File: tb/test_vid_ref_stepper.sv
`timescale 1ns/1ps
module test_vid_ref_stepper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [4:0]  vid_code = 5'd10;
  logic        step_tick = 1'b0;
  logic [5:0]  ofs_mv = 6'd0;
  logic [10:0] ref_mv;
  logic        settled;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tick_period = 2;
  bit done = 0;
  string tag = "R9";

  // behavioural reference state
  int m_ref = 0, m_cand = 0, m_acc = 0, m_ph = 0; // 0 off, 1 ramp, 2 track
  int x_mv;

  always #2.5 clk = ~clk;

  vid_ref_stepper i_vid_ref_stepper (
    .clk(clk), .rst_n(rst_n), .en(en), .vid_code(vid_code),
    .step_tick(step_tick), .ofs_mv(ofs_mv), .ref_mv(ref_mv), .settled(settled)
  );

  function automatic int target_of(int c);
    return (c > 30) ? 800 : 1550 - 25 * c;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      int tgt, o, e_out, e_set;
      @(posedge clk);
      tgt = target_of(m_acc);
      if (!rst_n) begin
        m_ref = 0; m_cand = 0; m_acc = 0; m_ph = 0;
      end else begin
        if (!en) begin
          m_ph = 0; m_ref = 0;
        end else if (m_ph == 0) begin
          m_ph = 1;
        end else if (m_ph == 1 && m_ref == tgt) begin
          m_ph = 2;
        end else if (step_tick && m_ref != tgt) begin
          m_ref += (m_ref < tgt) ? 25 : -25;
        end
        if (step_tick) begin
          if (int'(vid_code) == m_cand) m_acc = int'(vid_code);
          m_cand = int'(vid_code);
        end
      end
      #1;
      o = (int'(ofs_mv) > 50) ? 50 : int'(ofs_mv);
      e_out = (m_ph == 0) ? 0 : m_ref + o;
      e_set = (m_ph == 2 && m_ref == target_of(m_acc)) ? 1 : 0;
      chk(tag, int'(ref_mv), e_out);
      chk(tag, int'(settled), e_set);
      cyc++;
      if (tick_period != 0) step_tick = ((cyc % tick_period) == 0);
    end
  endtask

  task automatic pulse();
    step_tick = 1'b1; run(1);
    step_tick = 1'b0; run(1);
  endtask

  initial begin
    #400us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    tag = "R9"; run(3);
    chk("R9", int'(ref_mv), 0);
    chk("R9", int'(settled), 0);
    #1 rst_n = 1'b1;

    // R8 held off, filter still accepts code 10
    tag = "R8"; run(20);
    chk("R8", int'(ref_mv), 0);

    // R5 soft start from zero
    tag = "R5"; en = 1'b1; run(1);
    chk("R5", int'(ref_mv), 0);
    chk("R5", int'(settled), 0);
    run(20);
    chk("R5", int'(ref_mv > 0 && ref_mv < 11'd1300), 1);
    run(200);
    chk("R1", int'(ref_mv), 1300);
    chk("R6", int'(settled), 1);

    // R7 offset and its clamp
    tag = "R7"; ofs_mv = 6'd37; run(1);
    chk("R7", int'(ref_mv), 1337);
    ofs_mv = 6'd63; run(1);
    chk("R7", int'(ref_mv), 1350);

    // R6 / R4 downward move overtaken by an upward one
    tag = "R6"; vid_code = 5'd20; run(6);
    chk("R6", int'(settled), 0);
    tag = "R4"; run(12);
    x_mv = int'(ref_mv);
    vid_code = 5'd5; run(20);
    chk("R4", int'(int'(ref_mv) > x_mv), 1);
    run(200);
    chk("R4", int'(ref_mv), 1475);

    // R2 single-tick glitch is discarded, two-tick change is taken
    tag = "R2"; tick_period = 0; step_tick = 1'b0;
    vid_code = 5'd0; pulse();
    vid_code = 5'd5; pulse(); pulse();
    chk("R2", int'(ref_mv), 1475);
    chk("R2", int'(settled), 1);
    vid_code = 5'd0; pulse();
    chk("R2", int'(settled), 1);
    pulse();
    chk("R2", int'(settled), 0);
    tick_period = 1; run(20);
    chk("R1", int'(ref_mv), 1600);

    // R1 clamp of the top codes
    tag = "R1"; tick_period = 2; vid_code = 5'd31; run(200);
    chk("R1", int'(ref_mv), 850);
    vid_code = 5'd30; run(20);
    chk("R1", int'(ref_mv), 850);
    chk("R1", int'(settled), 1);

    // R3 no motion without ticks, one step per tick
    tag = "R3"; tick_period = 0; step_tick = 1'b0; vid_code = 5'd0; run(20);
    chk("R3", int'(ref_mv), 850);
    pulse(); pulse();
    chk("R3", int'(ref_mv), 850);
    pulse();
    chk("R3", int'(ref_mv), 875);
    pulse();
    chk("R3", int'(ref_mv), 900);

    // R8 disable, then R5 restart from zero
    tag = "R8"; en = 1'b0; run(1);
    chk("R8", int'(ref_mv), 0);
    chk("R8", int'(settled), 0);
    run(5);
    tag = "R5"; en = 1'b1; run(1);
    chk("R5", int'(ref_mv), 50);
    tick_period = 2; run(200);
    chk("R5", int'(ref_mv), 1600);
    chk("R6", int'(settled), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule